// File: doc/BRIEF.md
# CAN Data Frame Transmitter

This block sends a single standard-format CAN data frame (11-bit identifier) on a transmit line that behaves like an open-drain output. While it sends, it reads the shared receive line back and reports how the attempt ended. A start strobe latches the identifier, up to eight payload bytes, a byte count and a bit length given in clock cycles. The block then builds the control field, computes the CRC, inserts stuff bits, sends the delimiters and end-of-frame, and ends with a one-cycle done pulse and a two-bit result code.

The receive line is the wired-AND of every node's transmit line, so the block learns from it whether another node won arbitration, whether a receiver acknowledged, and whether a bit was corrupted. It makes one attempt per start and never retries. The bit length given at start must be at least four cycles. The payload is a single vector: its most significant bit goes on the bus first, and byte 0 is `data_i[63:56]`.

Top module: `can_frame_tx`

## Requirements
- R1: After reset and whenever no frame is in progress, `tx_o` is 1 (recessive), `busy_o` is 0 and `done_o` is 0.
- R2: A high `start_i` while idle begins a frame in the next cycle. The frame is a dominant start bit, then `id_i` with its most significant bit first, then three dominant bits (remote, extension, reserved), then the 4-bit length code with its most significant bit first, then the payload bytes starting at `data_i[63]`. Each bit lasts exactly `bit_time_i` cycles, using the value latched at start.
- R3: A byte count above 8 is sent as 8, in both the length code and the payload length. Payload bits beyond the counted bytes never reach the bus.
- R4: After the payload come 15 CRC bits, most significant first. The CRC uses polynomial 0x4599 and a zero start value, and it covers every unstuffed bit from the start bit to the last payload bit.
- R5: From the start bit through the last CRC bit, five equal consecutive bits on the bus are followed by one bit of the opposite value. This includes the case where the fifth bit is the last CRC bit, and the inserted bit counts toward the next run.
- R6: The CRC delimiter, the acknowledge slot, the acknowledge delimiter and seven end-of-frame bits are all sent recessive. After the last end-of-frame bit, `done_o` is high for one cycle, `busy_o` falls, and `result_o` = 0 (success).
- R7: The receive line is read once per bit, in the cycle whose offset from the start of the bit equals `bit_time_i/2` (integer division). Dominant levels in any other cycle of the bit have no effect.
- R8: If a recessive identifier or remote bit (not a stuff bit) reads back dominant, the attempt ends with `result_o` = 2. `tx_o` is recessive from the `done_o` cycle onward.
- R9: Any other mismatch between the sent bit and the read bit, outside the acknowledge slot, ends the attempt with `result_o` = 1.
- R10: A recessive read in the acknowledge slot ends the attempt with `result_o` = 3.
- R11: `start_i` has no effect while `busy_o` is high.
- R12: `result_o` keeps the code of the last finished attempt until the next `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame when idle |
| id_i | input | 11 | Frame identifier |
| data_i | input | 64 | Payload, byte 0 in bits 63:56 |
| nbytes_i | input | 4 | Number of payload bytes (values above 8 are sent as 8) |
| bit_time_i | input | 16 | Length of one bus bit in clock cycles (at least 4) |
| rx_i | input | 1 | Bus level read back |
| tx_o | output | 1 | Transmit line, 1 = recessive |
| busy_o | output | 1 | High while a frame is being sent |
| done_o | output | 1 | One-cycle pulse when an attempt ends |
| result_o | output | 2 | 0 success, 1 bus error, 2 arbitration lost, 3 no acknowledge |

## Verification
The hardest cases to reach are disturbances that land on one exact bit of a stuffed frame, such as a recessive identifier bit, a delimiter, or a single cycle inside a bit. Their position depends on where the stuff bits fall. The stimulus first builds the expected stuffed bit stream on its own, then acts as the second node on the wired-AND bus. Counting bits and cycles in that stream, it pulls the line dominant for a whole bit, for only the sampling cycle, or for every cycle except the sampling cycle, and it supplies the acknowledge bit when a success is expected.

// File: rtl/can_tx_pkg.sv
package can_tx_pkg;

    localparam int ID_W         = 11;
    localparam int DLC_W        = 4;
    localparam int CRC_W        = 15;
    localparam int HDR_BITS     = 1 + ID_W + 3 + DLC_W;   // start, id, three control bits, length code
    localparam int TAIL_BITS    = 10;                     // crc delim, ack slot, ack delim, 7 eof
    localparam int ACK_TAIL_IDX = 1;
    localparam int STUFF_RUN    = 5;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_BUS_ERR  = 2'd1,
        RES_ARB_LOST = 2'd2,
        RES_NO_ACK   = 2'd3
    } tx_result_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FRAME = 2'd1,
        PH_TAIL  = 2'd2
    } tx_phase_e;

endpackage

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int BT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [BT_W-1:0] bit_time_i,
    output logic            sample_o,
    output logic            end_o
);

    logic [BT_W-1:0] cnt_d, cnt_q;

    assign sample_o = run_i && (cnt_q == (bit_time_i >> 1));
    assign end_o    = run_i && (cnt_q == (bit_time_i - BT_W'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || end_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + BT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_SAMPLE_BEFORE_END: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> !end_o); // R7

    AST_COUNT_IN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < bit_time_i)); // R2

endmodule

// File: rtl/can_crc15.sv
module can_crc15 #(
    parameter int           W    = 15,
    parameter logic [W-1:0] POLY = 15'h4599
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         shift_i,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);

    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    assign fb    = bit_i ^ crc_q[W-1];
    assign crc_o = crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear_i) begin
            crc_d = '0;
        end else if (shift_i) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

endmodule

// File: rtl/can_stuff_tracker.sv
module can_stuff_tracker #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic first_i,
    input  logic bit_i,
    output logic due_o
);

    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [RUN_W-1:0] run_d, run_q;
    logic             last_d, last_q;

    assign due_o = (run_q == RUN_W'(RUN_LEN));

    always_comb begin
        run_d  = run_q;
        last_d = last_q;
        if (load_i) begin
            last_d = bit_i;
            if (first_i || (bit_i != last_q)) begin
                run_d = RUN_W'(1);
            end else begin
                run_d = run_q + RUN_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else begin
            run_q  <= run_d;
            last_q <= last_d;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(RUN_LEN)); // R5

endmodule

// File: rtl/can_frame_tx.sv
module can_frame_tx
    import can_tx_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    parameter int BT_W       = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [ID_W-1:0]         id_i,
    input  logic [DATA_BYTES*8-1:0] data_i,
    input  logic [DLC_W-1:0]        nbytes_i,
    input  logic [BT_W-1:0]         bit_time_i,
    input  logic                    rx_i,
    output logic                    tx_o,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [1:0]              result_o
);

    localparam int DATA_W = DATA_BYTES * 8;
    localparam int POS_W  = $clog2(HDR_BITS + DATA_W + CRC_W + 1);
    localparam int TAIL_W = $clog2(TAIL_BITS);
    localparam logic [POS_W-1:0]  HDR_P    = POS_W'(HDR_BITS);
    localparam logic [POS_W-1:0]  ARB_HI   = POS_W'(ID_W + 1);
    localparam logic [TAIL_W-1:0] TAIL_END = TAIL_W'(TAIL_BITS - 1);
    localparam logic [TAIL_W-1:0] ACK_IDX  = TAIL_W'(ACK_TAIL_IDX);

    typedef struct packed {
        tx_phase_e         phase;
        logic [POS_W-1:0]  pos;
        logic [TAIL_W-1:0] tail;
        logic              tx;
        logic              stuffed;
        logic [ID_W-1:0]   id;
        logic [DATA_W-1:0] data;
        logic [DLC_W-1:0]  nb;
        logic [BT_W-1:0]   bt;
        tx_result_e        result;
        logic              done;
    } tx_state_t;

    tx_state_t s_d, s_q;

    logic              tmr_sample, tmr_end;
    logic              crc_clear, crc_shift, crc_bit;
    logic [CRC_W-1:0]  crc_val;
    logic              st_load, st_first, st_bit, st_due;

    logic [POS_W-1:0]    nxt_pos, crc_start, frame_len;
    logic [HDR_BITS-1:0] hdr, hdr_sh;
    logic [DATA_W-1:0]   data_sh;
    logic [CRC_W-1:0]    crc_sh;
    logic                frame_bit;
    logic                in_arb;
    logic [DLC_W-1:0]    nb_in;

    can_bit_timer #(.BT_W(BT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (s_q.phase != PH_IDLE),
        .bit_time_i (s_q.bt),
        .sample_o   (tmr_sample),
        .end_o      (tmr_end)
    );

    can_crc15 #(.W(CRC_W), .POLY(15'h4599)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (crc_clear),
        .shift_i (crc_shift),
        .bit_i   (crc_bit),
        .crc_o   (crc_val)
    );

    can_stuff_tracker #(.RUN_LEN(STUFF_RUN)) u_stuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (st_load),
        .first_i (st_first),
        .bit_i   (st_bit),
        .due_o   (st_due)
    );

    // Field boundaries and the unstuffed bit at the next position
    always_comb begin
        nb_in     = (nbytes_i > DLC_W'(DATA_BYTES)) ? DLC_W'(DATA_BYTES) : nbytes_i;
        nxt_pos   = s_q.pos + POS_W'(1);
        crc_start = HDR_P + (POS_W'(s_q.nb) << 3);
        frame_len = crc_start + POS_W'(CRC_W);
        hdr       = {1'b0, s_q.id, 3'b000, s_q.nb};
        hdr_sh    = hdr << nxt_pos;
        data_sh   = s_q.data << (nxt_pos - HDR_P);
        crc_sh    = crc_val << (nxt_pos - crc_start);
        if (nxt_pos < HDR_P) begin
            frame_bit = hdr_sh[HDR_BITS-1];
        end else if (nxt_pos < crc_start) begin
            frame_bit = data_sh[DATA_W-1];
        end else begin
            frame_bit = crc_sh[CRC_W-1];
        end
        in_arb = (s_q.phase == PH_FRAME) && !s_q.stuffed && s_q.tx &&
                 (s_q.pos >= POS_W'(1)) && (s_q.pos <= ARB_HI);
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        crc_clear = 1'b0;
        crc_shift = 1'b0;
        crc_bit   = 1'b0;
        st_load   = 1'b0;
        st_first  = 1'b0;
        st_bit    = 1'b0;

        case (s_q.phase)
            PH_IDLE: begin
                s_d.tx = 1'b1;
                if (start_i) begin
                    s_d.phase   = PH_FRAME;
                    s_d.pos     = '0;
                    s_d.tail    = '0;
                    s_d.tx      = 1'b0;
                    s_d.stuffed = 1'b0;
                    s_d.id      = id_i;
                    s_d.data    = data_i;
                    s_d.nb      = nb_in;
                    s_d.bt      = bit_time_i;
                    crc_clear   = 1'b1;
                    st_load     = 1'b1;
                    st_first    = 1'b1;
                    st_bit      = 1'b0;
                end
            end

            default: begin
                if (tmr_sample) begin
                    if (s_q.phase == PH_TAIL && s_q.tail == ACK_IDX) begin
                        if (rx_i) begin
                            s_d.phase  = PH_IDLE;
                            s_d.tx     = 1'b1;
                            s_d.done   = 1'b1;
                            s_d.result = RES_NO_ACK;
                        end
                    end else if (rx_i != s_q.tx) begin
                        s_d.phase  = PH_IDLE;
                        s_d.tx     = 1'b1;
                        s_d.done   = 1'b1;
                        s_d.result = in_arb ? RES_ARB_LOST : RES_BUS_ERR;
                    end
                end else if (tmr_end) begin
                    if (s_q.phase == PH_FRAME) begin
                        if (st_due) begin
                            s_d.tx      = ~s_q.tx;
                            s_d.stuffed = 1'b1;
                            st_load     = 1'b1;
                            st_bit      = ~s_q.tx;
                        end else if (nxt_pos < frame_len) begin
                            s_d.tx      = frame_bit;
                            s_d.pos     = nxt_pos;
                            s_d.stuffed = 1'b0;
                            st_load     = 1'b1;
                            st_bit      = frame_bit;
                            if (nxt_pos < crc_start) begin
                                crc_shift = 1'b1;
                                crc_bit   = frame_bit;
                            end
                        end else begin
                            s_d.phase   = PH_TAIL;
                            s_d.tail    = '0;
                            s_d.tx      = 1'b1;
                            s_d.stuffed = 1'b0;
                        end
                    end else begin
                        if (s_q.tail == TAIL_END) begin
                            s_d.phase  = PH_IDLE;
                            s_d.tx     = 1'b1;
                            s_d.done   = 1'b1;
                            s_d.result = RES_OK;
                        end else begin
                            s_d.tail = s_q.tail + TAIL_W'(1);
                        end
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.phase   <= PH_IDLE;
            s_q.tx      <= 1'b1;
            s_q.result  <= RES_OK;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_o     = s_q.tx;
    assign busy_o   = (s_q.phase != PH_IDLE);
    assign done_o   = s_q.done;
    assign result_o = s_q.result;

    AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o); // R1

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R6

    AST_TAIL_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_TAIL) |-> tx_o); // R6

    AST_STUFF_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $rose(s_q.stuffed)) |-> (tx_o != $past(tx_o))); // R5

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && result_o == 2'd2) |-> (tx_o && $past(tx_o))); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !tmr_sample && !tmr_end) |=> (busy_o && $stable(s_q.pos))); // R11

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o)); // R12

endmodule

// File: tb/sim_can_frame_tx.sv
module sim_can_frame_tx;
    import can_tx_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [10:0] idv;
    logic [63:0] datav;
    logic [3:0]  nbv;
    logic [15:0] btv;
    logic        node_tx;
    logic        rx;
    logic        tx, busy, done;
    logic [1:0]  result;

    int total = 0;
    int bad   = 0;
    logic [1:0] exp_q[$];
    bit         frame_q[$];
    int         ack_idx;

    always #5 clk = ~clk;

    assign rx = tx & node_tx;

    can_frame_tx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .id_i       (idv),
        .data_i     (datav),
        .nbytes_i   (nbv),
        .bit_time_i (btv),
        .rx_i       (rx),
        .tx_o       (tx),
        .busy_o     (busy),
        .done_o     (done),
        .result_o   (result)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_for(input logic [1:0] code);
        case (code)
            2'd0:    return "R6";
            2'd1:    return "R9";
            2'd2:    return "R8";
            default: return "R10";
        endcase
    endfunction

    // Expected bus stream built from the requirements
    task automatic build(input logic [10:0] i, input logic [63:0] d, input int n);
        bit          raw[$];
        int          nb;
        logic [3:0]  dlc;
        logic [14:0] c;
        int          run;
        bit          last;
        bit          fb;
        nb  = (n > 8) ? 8 : n;
        dlc = 4'(nb);
        c   = '0;
        raw.push_back(1'b0);
        for (int k = 10; k >= 0; k--) raw.push_back(i[k]);
        for (int k = 0; k < 3; k++) raw.push_back(1'b0);
        for (int k = 3; k >= 0; k--) raw.push_back(dlc[k]);
        for (int k = 0; k < nb * 8; k++) raw.push_back(d[63-k]);
        foreach (raw[k]) begin
            fb = raw[k] ^ c[14];
            c  = {c[13:0], 1'b0};
            if (fb) c = c ^ 15'h4599;
        end
        for (int k = 14; k >= 0; k--) raw.push_back(c[k]);
        frame_q.delete();
        run  = 0;
        last = 1'b0;
        foreach (raw[k]) begin
            if (run == 5) begin
                frame_q.push_back(~last);
                last = ~last;
                run  = 1;
            end
            frame_q.push_back(raw[k]);
            if (run > 0 && raw[k] == last) run++;
            else run = 1;
            last = raw[k];
        end
        if (run == 5) frame_q.push_back(~last);
        ack_idx = frame_q.size() + 1;
        for (int k = 0; k < 10; k++) frame_q.push_back(1'b1);
    endtask

    function automatic int first_one_from(input int s);
        for (int k = s; k < frame_q.size(); k++) if (frame_q[k]) return k;
        return s;
    endfunction

    // mode: 0 none, 1 dominant whole bit, 2 dominant except sample cycle, 3 dominant only at sample cycle
    task automatic send(input logic [10:0] i, input logic [63:0] d, input int n, input int bt,
                        input int f_idx, input int f_mode, input logic [1:0] exp_res,
                        input bit give_ack, input bit poke, input string tag);
        int  half;
        bit  stop;
        bit  drive0;
        half = bt / 2;
        stop = 1'b0;
        idv = i; datav = d; nbv = 4'(n); btv = 16'(bt);
        exp_q.push_back(exp_res);
        @(negedge clk);
        start = 1'b1;
        for (int k = 0; k < frame_q.size() && !stop; k++) begin
            for (int j = 0; j < bt && !stop; j++) begin
                @(negedge clk);
                start  = poke && (k == 5) && (j == 1);
                drive0 = (give_ack && k == ack_idx) ||
                         (k == f_idx && (f_mode == 1 || (f_mode == 2 && j != half) ||
                                         (f_mode == 3 && j == half)));
                node_tx = !drive0;
                if (j == half) begin
                    chk(tx == frame_q[k], tag, $sformatf("tx bit %0d", k), int'(tx), int'(frame_q[k]));
                    if ((k == f_idx && (f_mode == 1 || f_mode == 3)) || (!give_ack && k == ack_idx))
                        stop = 1'b1;
                end
            end
        end
        @(negedge clk);
        node_tx = 1'b1;
        start   = 1'b0;
        for (int w = 0; w < 50 && busy; w++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(!busy && tx, "R1", "idle after attempt", int'({busy, tx}), 1);
    endtask

    // Scoreboard monitor
    initial begin
        logic [1:0] e;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && done === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(result == e, tag_for(e), "result code", int'(result), int'(e));
                    chk(tx && !busy, "R8", "tx released at done", int'({tx, busy}), 2);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [1:0] held;
        rst_n = 1'b0; start = 1'b0; node_tx = 1'b1;
        idv = '0; datav = '0; nbv = '0; btv = 16'd8;
        repeat (3) @(negedge clk);
        chk(tx && !busy && !done, "R1", "reset state", int'({tx, busy, done}), 4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(tx && !busy, "R1", "idle after reset", int'({tx, busy}), 2);

        // R2: basic frame, alternating id, two bytes
        build(11'h555, 64'hA5C3_0000_0000_0000, 2);
        send(11'h555, 64'hA5C3_0000_0000_0000, 2, 8, -1, 0, 2'd0, 1'b1, 1'b0, "R2");

        // R5: all-zero id, no payload, heavy stuffing
        build(11'h000, 64'h0, 0);
        send(11'h000, 64'h0, 0, 8, -1, 0, 2'd0, 1'b1, 1'b0, "R5");

        // R5: all-ones id and payload
        build(11'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 8);
        send(11'h7FF, 64'hFFFF_FFFF_FFFF_FFFF, 8, 6, -1, 0, 2'd0, 1'b1, 1'b0, "R5");

        // R4: varied eight-byte payload
        build(11'h2B4, 64'h0123_4567_89AB_CDEF, 8);
        send(11'h2B4, 64'h0123_4567_89AB_CDEF, 8, 8, -1, 0, 2'd0, 1'b1, 1'b0, "R4");

        // R3: byte count above eight, and unsent bytes ignored
        build(11'h1C7, 64'h1122_3344_5566_7788, 12);
        send(11'h1C7, 64'h1122_3344_5566_7788, 12, 8, -1, 0, 2'd0, 1'b1, 1'b0, "R3");
        build(11'h1C7, 64'h1122_0000_0000_0000, 2);
        send(11'h1C7, 64'h1122_DEAD_BEEF_F00D, 2, 8, -1, 0, 2'd0, 1'b1, 1'b0, "R3");

        // R12: result held
        held = result;
        repeat (20) @(negedge clk);
        chk(result == held, "R12", "result held while idle", int'(result), int'(held));

        // R10: no acknowledge
        build(11'h3A1, 64'h7700_0000_0000_0000, 1);
        send(11'h3A1, 64'h7700_0000_0000_0000, 1, 8, -1, 0, 2'd3, 1'b0, 1'b0, "R10");

        // R8: lost arbitration on first identifier bit
        build(11'h555, 64'h0, 0);
        send(11'h555, 64'h0, 0, 8, 1, 1, 2'd2, 1'b1, 1'b0, "R8");
        held = result;
        repeat (10) @(negedge clk);
        chk(result == held, "R12", "lost code held", int'(result), 2);

        // R9: dominant on a recessive payload bit, on CRC delimiter, on ack delimiter
        build(11'h0F0, 64'h5A5A_0000_0000_0000, 2);
        send(11'h0F0, 64'h5A5A_0000_0000_0000, 2, 8, first_one_from(22), 1, 2'd1, 1'b1, 1'b0, "R9");
        build(11'h0F0, 64'h5A5A_0000_0000_0000, 2);
        send(11'h0F0, 64'h5A5A_0000_0000_0000, 2, 8, ack_idx - 1, 1, 2'd1, 1'b1, 1'b0, "R9");
        build(11'h0F0, 64'h5A5A_0000_0000_0000, 2);
        send(11'h0F0, 64'h5A5A_0000_0000_0000, 2, 8, ack_idx + 1, 1, 2'd1, 1'b1, 1'b0, "R9");

        // R7: glitches away from the sample cycle are ignored, at the sample cycle they count
        build(11'h6C3, 64'h3C00_0000_0000_0000, 1);
        send(11'h6C3, 64'h3C00_0000_0000_0000, 1, 7, ack_idx + 1, 2, 2'd0, 1'b1, 1'b0, "R7");
        build(11'h6C3, 64'h3C00_0000_0000_0000, 1);
        send(11'h6C3, 64'h3C00_0000_0000_0000, 1, 6, first_one_from(22), 2, 2'd0, 1'b1, 1'b0, "R7");
        build(11'h6C3, 64'h3C00_0000_0000_0000, 1);
        send(11'h6C3, 64'h3C00_0000_0000_0000, 1, 6, ack_idx - 1, 3, 2'd1, 1'b1, 1'b0, "R7");

        // R11: start pulse in mid-frame changes nothing
        build(11'h111, 64'h8100_0000_0000_0000, 1);
        send(11'h111, 64'h8100_0000_0000_0000, 1, 8, -1, 0, 2'd0, 1'b1, 1'b1, "R11");
        repeat (20) @(negedge clk);
        chk(!busy && exp_q.size() == 0, "R11", "no second attempt", int'(busy), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule